// File: doc/BRIEF.md
# Processor Message Port with Coherence Steering

This block sits beside a directory-based coherence controller and gives the local processor a way to send and receive raw network packets. Every packet starts with one header word. The header holds the sender's identity, two word counts and an opcode. After the header come the operand words and then the data words. The opcode decides what kind of packet it is. Coherence-protocol packets are meant for the directory hardware. Interrupt-class packets carry software messages between processors.

On the send side, the processor writes a complete packet into an outbound queue one word at a time. A packet is either admitted whole or refused at its header, so a partial packet is never committed. The queue then drains onto a word-wide network output that uses valid/ready handshaking. On the receive side, the block parses each arriving packet. Protocol packets stream straight to the directory port. Interrupt-class packets are stored whole in an inbound queue. While that queue holds anything, a trap line to the processor stays high. When the processor sets an intercept control, it can also capture protocol packets itself, which lets a software handler take part in coherence traffic.

Top module: `msgnet_port`

## Requirements
- R1: A header word is laid out as source ID in bits [31:24], operand-word count in [23:20], data-word count in [19:16], opcode in [15:8], and unused bits in [7:0]. A packet is 1 + operand count + data count words long, in that order.
- R2: Opcode bit 7 (header bit 15) selects the class. A 1 means interrupt class and a 0 means protocol class.
- R3: When a header is offered and the outbound queue has fewer free words than the packet length, tx_full is high and the word is not taken. A packet that exactly fills the remaining space is admitted. Once a header is taken, every further word of that packet is taken without tx_full.
- R4: Outbound words leave on the network output in enqueue order, at most one per cycle. While net_out_valid is high and net_out_ready is low, the valid and the data are held.
- R5: An interrupt-class packet is written whole, in arrival order, into the inbound queue. The oldest word is shown on rx_data and is removed by rx_pop.
- R6: A protocol-class packet whose header arrives while rx_intercept is low goes word by word to the directory port, with dir_last marking its final word. If rx_intercept is high at its header, the packet goes to the inbound queue instead.
- R7: net_in_ready is low on a header that routes to the inbound queue when the queue has fewer free words than the packet length. No word is dropped. Once such a header is taken, the packet's body words are never stalled.
- R8: rx_trap is high exactly while the inbound queue holds at least one word.
- R9: While a protocol packet is routed to the directory port, net_in_ready follows dir_ready.
- R10: After reset, both queues are empty, rx_trap and net_out_valid are low, and the parser expects a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_valid | input | 1 | Processor offers an outbound word |
| tx_data | input | 32 | Outbound word (header first) |
| tx_full | output | 1 | Offered header refused for lack of room |
| net_out_valid | output | 1 | Network output word valid |
| net_out_data | output | 32 | Network output word |
| net_out_ready | input | 1 | Network accepts the output word |
| net_in_valid | input | 1 | Network input word valid |
| net_in_data | input | 32 | Network input word |
| net_in_ready | output | 1 | Block accepts the input word |
| dir_valid | output | 1 | Protocol word valid toward the directory |
| dir_data | output | 32 | Protocol word toward the directory |
| dir_last | output | 1 | Final word of the protocol packet |
| dir_ready | input | 1 | Directory accepts the word |
| rx_intercept | input | 1 | Capture protocol packets into the inbound queue |
| rx_pop | input | 1 | Processor removes the oldest inbound word |
| rx_data | output | 32 | Oldest inbound word |
| rx_trap | output | 1 | Inbound queue non-empty |

## Verification
The hardest cases to reach are the exact-fit boundaries: a packet that fills the last free words of a queue, followed by a one-word packet that must then be refused or held off. The stimulus reaches them by holding net_out_ready low, or rx_pop low, while it enqueues packets whose lengths add up to the queue depth exactly. It then releases the consumer and checks that the held packet moves through intact. A behavioural model built on queues predicts every output on every cycle. That includes directory-port stalls caused by a pattern on dir_ready, and the intercept path.

// File: rtl/msgnet_pkg.sv
package msgnet_pkg;
  localparam int WORD_W = 32;
  localparam int CNT_W  = 4;
  localparam int LEN_W  = CNT_W + 2;

  typedef struct packed {
    logic [7:0]       src;
    logic [CNT_W-1:0] n_opd;
    logic [CNT_W-1:0] n_dat;
    logic [7:0]       opcode;
    logic [7:0]       spare;
  } hdr_t;

  function automatic logic [LEN_W-1:0] pkt_words(input logic [WORD_W-1:0] w);
    hdr_t h;
    h = hdr_t'(w);
    return LEN_W'(1) + LEN_W'(h.n_opd) + LEN_W'(h.n_dat);
  endfunction

  function automatic logic is_msg_class(input logic [WORD_W-1:0] w);
    hdr_t h;
    h = hdr_t'(w);
    return h.opcode[7];
  endfunction

  function automatic logic room_for(input int unsigned need, input int unsigned avail);
    return need <= avail;
  endfunction
endpackage

// File: rtl/msgnet_fifo.sv
module msgnet_fifo #(
  parameter int DEPTH = 32,
  parameter int W = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic [CW-1:0] count,
  output logic [CW-1:0] free
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      count <= count + CW'(push) - CW'(pop);
    end
  end

  assign head = mem[rd_ptr];
  assign free = CW'(DEPTH) - count;

  // R3 R7: admission control must never let a queue overflow
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(DEPTH)) |-> !(push && !pop));
  // R4 R5: nothing is read out of an empty queue
  a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> !pop);
endmodule

// File: rtl/msgnet_tx_admit.sv
module msgnet_tx_admit
  import msgnet_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [LEN_W-1:0] wr_len,
  input  logic [CW-1:0]    q_free,
  output logic             full,
  output logic             push,
  output logic             at_head
);
  logic [LEN_W-1:0] left;

  assign at_head = (left == '0);
  assign full    = wr_valid && at_head && !room_for(int'(wr_len), int'(q_free));
  assign push    = wr_valid && !full;

  always_ff @(posedge clk) begin
    if (!rst_n) left <= '0;
    else if (push) left <= at_head ? wr_len - 1'b1 : left - 1'b1;
  end

  // R3: inside an admitted packet the processor is never refused
  a_r3_body_never_full: assert property (@(posedge clk) disable iff (!rst_n)
    !at_head |-> !full);
  // R3: an admitted header always had room reserved for the whole packet
  a_r3_head_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (push && at_head) |-> (int'(q_free) >= int'(wr_len)));
endmodule

// File: rtl/msgnet_rx_sort.sv
module msgnet_rx_sort
  import msgnet_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [LEN_W-1:0] in_len,
  input  logic             in_msg,
  input  logic             intercept,
  input  logic [CW-1:0]    q_free,
  input  logic             dir_ready,
  output logic             in_ready,
  output logic             q_push,
  output logic             dir_valid,
  output logic             dir_last,
  output logic             at_head
);
  logic [LEN_W-1:0] left;
  logic             to_cpu;
  logic             route_cpu;
  logic [LEN_W-1:0] cur_left;
  logic             take;

  assign at_head   = (left == '0);
  assign route_cpu = at_head ? (in_msg || intercept) : to_cpu;
  assign cur_left  = at_head ? in_len : left;

  always_comb begin
    if (route_cpu) in_ready = at_head ? room_for(int'(in_len), int'(q_free)) : 1'b1;
    else           in_ready = dir_ready;
  end

  assign take      = in_valid && in_ready;
  assign q_push    = take && route_cpu;
  assign dir_valid = in_valid && !route_cpu;
  assign dir_last  = !route_cpu && (cur_left == LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left   <= '0;
      to_cpu <= 1'b0;
    end else if (take) begin
      left <= cur_left - 1'b1;
      if (at_head) to_cpu <= route_cpu;
    end
  end

  // R7: the body of a queued packet is never held off
  a_r7_body_flows: assert property (@(posedge clk) disable iff (!rst_n)
    (!at_head && to_cpu && in_valid) |-> in_ready);
  // R6: a word marked last that the directory takes closes the packet
  a_r6_last_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_valid && dir_ready && dir_last) |=> at_head);
  // R9: a word for the directory is only taken when the directory is ready
  a_r9_dir_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_valid && !dir_ready) |-> !in_ready);
endmodule

// File: rtl/msgnet_port.sv
module msgnet_port
  import msgnet_pkg::*;
#(
  parameter int OUT_DEPTH = 32,
  parameter int IN_DEPTH = 32,
  localparam int OCW = $clog2(OUT_DEPTH) + 1,
  localparam int ICW = $clog2(IN_DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_valid,
  input  logic [WORD_W-1:0] tx_data,
  output logic              tx_full,
  output logic              net_out_valid,
  output logic [WORD_W-1:0] net_out_data,
  input  logic              net_out_ready,
  input  logic              net_in_valid,
  input  logic [WORD_W-1:0] net_in_data,
  output logic              net_in_ready,
  output logic              dir_valid,
  output logic [WORD_W-1:0] dir_data,
  output logic              dir_last,
  input  logic              dir_ready,
  input  logic              rx_intercept,
  input  logic              rx_pop,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_trap
);
  logic [OCW-1:0] oq_count, oq_free;
  logic [ICW-1:0] iq_count, iq_free;
  logic           oq_push, oq_pop, iq_push, iq_pop;
  logic           tx_at_head, rx_at_head;

  msgnet_tx_admit #(.CW(OCW)) u_admit (
    .clk(clk), .rst_n(rst_n), .wr_valid(tx_valid), .wr_len(pkt_words(tx_data)),
    .q_free(oq_free), .full(tx_full), .push(oq_push), .at_head(tx_at_head)
  );

  msgnet_fifo #(.DEPTH(OUT_DEPTH), .W(WORD_W)) u_outq (
    .clk(clk), .rst_n(rst_n), .push(oq_push), .push_data(tx_data), .pop(oq_pop),
    .head(net_out_data), .count(oq_count), .free(oq_free)
  );

  assign net_out_valid = (oq_count != '0);
  assign oq_pop        = net_out_valid && net_out_ready;

  msgnet_rx_sort #(.CW(ICW)) u_sort (
    .clk(clk), .rst_n(rst_n), .in_valid(net_in_valid), .in_len(pkt_words(net_in_data)),
    .in_msg(is_msg_class(net_in_data)), .intercept(rx_intercept), .q_free(iq_free),
    .dir_ready(dir_ready), .in_ready(net_in_ready), .q_push(iq_push),
    .dir_valid(dir_valid), .dir_last(dir_last), .at_head(rx_at_head)
  );

  assign dir_data = net_in_data;

  msgnet_fifo #(.DEPTH(IN_DEPTH), .W(WORD_W)) u_inq (
    .clk(clk), .rst_n(rst_n), .push(iq_push), .push_data(net_in_data), .pop(iq_pop),
    .head(rx_data), .count(iq_count), .free(iq_free)
  );

  assign iq_pop  = rx_pop && (iq_count != '0);
  assign rx_trap = (iq_count != '0);

  // R4: a stalled output word is held unchanged
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (net_out_valid && !net_out_ready) |=> (net_out_valid && $stable(net_out_data)));
  // R8: the trap only rises after a word entered the inbound queue
  a_r8_trap_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_trap) |-> $past(iq_push));
  // R3: a refused header leaves the outbound queue untouched
  a_r3_refuse_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full && !oq_pop) |=> $stable(oq_count));
  // R10: the parsers only leave their header state by taking a word
  a_r10_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_at_head && !(net_in_valid && net_in_ready)) |=> rx_at_head);
  a_r10_tx_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_at_head && !oq_push) |=> tx_at_head);
endmodule

// File: tb/test_msgnet_port.sv
module test_msgnet_port;
  localparam int OD = 32;
  localparam int ID = 32;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, tx_valid, tx_full, net_out_valid, net_out_ready, net_in_valid, net_in_ready;
  logic dir_valid, dir_last, dir_ready, rx_intercept, rx_pop, rx_trap;
  logic [31:0] tx_data, net_out_data, net_in_data, dir_data, rx_data;

  msgnet_port #(.OUT_DEPTH(OD), .IN_DEPTH(ID)) i_msgnet_port (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_data(tx_data), .tx_full(tx_full),
    .net_out_valid(net_out_valid), .net_out_data(net_out_data), .net_out_ready(net_out_ready),
    .net_in_valid(net_in_valid), .net_in_data(net_in_data), .net_in_ready(net_in_ready),
    .dir_valid(dir_valid), .dir_data(dir_data), .dir_last(dir_last), .dir_ready(dir_ready),
    .rx_intercept(rx_intercept), .rx_pop(rx_pop), .rx_data(rx_data), .rx_trap(rx_trap)
  );

  int errs = 0, checks = 0, cyc = 0, seed = 1;
  int oq[$], iq[$], txs[$], rxs[$];
  int tx_left = 0, rx_left = 0;
  bit rx_cpu = 0;
  int n_refused = 0, n_bp = 0, n_icpt = 0, n_last = 0;
  int out_mode = 1, dir_mode = 1, rd_mode = 1;
  bit tx_en = 0, rx_en = 0, icpt = 0;
  bit done = 0;

  function automatic bit pat(int mode, int c);
    if (mode == 0) return 1'b0;
    if (mode == 1) return 1'b1;
    return (c % 3) != 0;
  endfunction

  // R1: length = 1 + operand count [23:20] + data count [19:16]
  function automatic int hlen(logic [31:0] h);
    return 1 + int'(h[23:20]) + int'(h[19:16]);
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic add_pkt(bit to_net_in, int src, int nops, int ndat, int opc);
    logic [31:0] h;
    h = {8'(src), 4'(nops), 4'(ndat), 8'(opc), 8'h00};
    if (to_net_in) rxs.push_back(int'(h)); else txs.push_back(int'(h));
    for (int i = 0; i < nops + ndat; i++) begin
      logic [31:0] w;
      w = {8'(src), 8'(i), 16'(seed)};
      seed++;
      if (to_net_in) rxs.push_back(int'(w)); else txs.push_back(int'(w));
    end
  endtask

  task automatic cycle();
    bit e_full, tx_acc, o_pop, head, rcpu, e_rdy, e_dv, r_take, i_pop;
    int rlen;
    logic [31:0] w;
    tx_valid      = tx_en && (txs.size() > 0);
    tx_data       = (txs.size() > 0) ? 32'(txs[0]) : 32'h0;
    net_out_ready = pat(out_mode, cyc);
    dir_ready     = pat(dir_mode, cyc + 1);
    rx_pop        = pat(rd_mode, cyc);
    net_in_valid  = rx_en && (rxs.size() > 0);
    net_in_data   = (rxs.size() > 0) ? 32'(rxs[0]) : 32'h0;
    rx_intercept  = icpt;
    #2;
    e_full = tx_valid && (tx_left == 0) && (hlen(tx_data) > OD - oq.size());
    chk(tx_full === e_full, "R3 tx_full", 32'(tx_full), 32'(e_full));
    if (e_full) n_refused++;
    chk(net_out_valid === (oq.size() > 0), "R4 net_out_valid", 32'(net_out_valid), 32'(oq.size() > 0));
    if (oq.size() > 0) chk(net_out_data === 32'(oq[0]), "R4 net_out_data", net_out_data, 32'(oq[0]));
    head = (rx_left == 0);
    // R2: header bit 15 set means interrupt class
    rcpu = head ? (net_in_data[15] || icpt) : rx_cpu;
    rlen = head ? hlen(net_in_data) : rx_left;
    e_rdy = rcpu ? (head ? (hlen(net_in_data) <= ID - iq.size()) : 1'b1) : dir_ready;
    if (net_in_valid) begin
      chk(net_in_ready === e_rdy, "R7 R9 net_in_ready", 32'(net_in_ready), 32'(e_rdy));
      if (rcpu && !e_rdy) n_bp++;
    end
    e_dv = net_in_valid && !rcpu;
    chk(dir_valid === e_dv, "R2 R6 dir_valid", 32'(dir_valid), 32'(e_dv));
    if (e_dv) begin
      chk(dir_data === net_in_data, "R6 dir_data", dir_data, net_in_data);
      chk(dir_last === (rlen == 1), "R6 dir_last", 32'(dir_last), 32'(rlen == 1));
      if (rlen == 1 && dir_ready) n_last++;
    end
    chk(rx_trap === (iq.size() > 0), "R8 rx_trap", 32'(rx_trap), 32'(iq.size() > 0));
    if (iq.size() > 0) chk(rx_data === 32'(iq[0]), "R5 rx_data", rx_data, 32'(iq[0]));
    tx_acc = tx_valid && !e_full;
    o_pop  = net_out_ready && (oq.size() > 0);
    r_take = net_in_valid && e_rdy;
    i_pop  = rx_pop && (iq.size() > 0);
    @(posedge clk);
    if (o_pop) void'(oq.pop_front());
    if (i_pop) void'(iq.pop_front());
    if (tx_acc) begin
      w = 32'(txs.pop_front());
      oq.push_back(int'(w));
      tx_left = (tx_left == 0) ? hlen(w) - 1 : tx_left - 1;
    end
    if (r_take) begin
      w = 32'(rxs.pop_front());
      if (rcpu) iq.push_back(int'(w));
      if (head) begin
        rx_cpu = rcpu;
        if (rcpu && !w[15]) n_icpt++;
      end
      rx_left = rlen - 1;
    end
    cyc++;
    @(negedge clk);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic drain(int maxc);
    for (int i = 0; i < maxc; i++) begin
      if (txs.size() == 0 && rxs.size() == 0 && oq.size() == 0 && iq.size() == 0) break;
      cycle();
    end
    chk(txs.size() == 0 && rxs.size() == 0 && oq.size() == 0 && iq.size() == 0,
        "R4 R5 drained", 32'(oq.size() + iq.size()), 32'h0);
  endtask

  always @(posedge clk) begin
    if (!done && cyc > 150000) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tx_valid = 0; tx_data = 0; net_out_ready = 0; net_in_valid = 0;
    net_in_data = 0; dir_ready = 0; rx_intercept = 0; rx_pop = 0;
    repeat (3) @(negedge clk);
    #2;
    // R10: reset state
    chk(net_out_valid === 1'b0, "R10 net_out_valid", 32'(net_out_valid), 0);
    chk(rx_trap === 1'b0, "R10 rx_trap", 32'(rx_trap), 0);
    chk(tx_full === 1'b0, "R10 tx_full", 32'(tx_full), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 R4: assorted lengths, stalling network output
    tx_en = 1; out_mode = 2;
    add_pkt(0, 3, 0, 0, 8'h91);
    add_pkt(0, 4, 3, 2, 8'h10);
    add_pkt(0, 5, 15, 15, 8'h82);
    add_pkt(0, 6, 1, 0, 8'h22);
    drain(400);

    // R3: exact fit then refusal while output is blocked
    out_mode = 0;
    add_pkt(0, 7, 10, 9, 8'h80);
    add_pkt(0, 8, 6, 5, 8'h81);
    add_pkt(0, 9, 0, 0, 8'h83);
    run(45);
    chk(n_refused > 0, "R3 refusal seen", 32'(n_refused), 1);
    chk(oq.size() == OD && txs.size() == 1, "R3 exact fit", 32'(oq.size()), 32'(OD));
    out_mode = 1;
    drain(200);

    // R5 R7 R8: inbound queue fills exactly, next header held off
    rx_en = 1; rd_mode = 0;
    add_pkt(1, 10, 10, 9, 8'h85);
    add_pkt(1, 11, 6, 5, 8'h86);
    add_pkt(1, 12, 0, 0, 8'h87);
    run(45);
    chk(n_bp > 0, "R7 backpressure seen", 32'(n_bp), 1);
    chk(iq.size() == ID && rxs.size() == 1, "R7 no drop", 32'(iq.size()), 32'(ID));
    rd_mode = 2;
    drain(300);

    // R6 R9: protocol packets to the directory with stalls
    dir_mode = 2;
    add_pkt(1, 13, 2, 1, 8'h12);
    add_pkt(1, 14, 0, 0, 8'h13);
    add_pkt(1, 15, 3, 0, 8'h95);
    add_pkt(1, 16, 4, 4, 8'h14);
    drain(300);
    chk(n_last == 3, "R6 packet ends", 32'(n_last), 3);

    // R6: intercept sends protocol packets to the inbound queue
    icpt = 1;
    add_pkt(1, 17, 2, 2, 8'h15);
    add_pkt(1, 18, 0, 1, 8'h16);
    drain(300);
    chk(n_icpt == 2, "R6 intercept", 32'(n_icpt), 2);
    icpt = 0;

    // mixed traffic, all sides throttled
    out_mode = 2; rd_mode = 2; dir_mode = 2;
    for (int k = 0; k < 6; k++) begin
      add_pkt(0, 20 + k, k, 15 - k, (k % 2) ? 8'h88 : 8'h08);
      add_pkt(1, 30 + k, 15 - k, k, (k % 2) ? 8'h89 : 8'h09);
    end
    drain(2000);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule